// File: doc/BRIEF.md
# SDRAM Command and Refresh Sequencer

This block sits on the controller side of a single four-bank SDRAM device and turns simple access requests into the device's command stream. A request names a bank, a row, a column, a direction and whether the row should close on its own after the burst. The sequencer opens the row with ACTIVE, waits the row-to-column delay and then issues READ or WRITE. When a previous access left a row open, a PRECHARGE of all banks comes first. Data transfer is handled elsewhere. The sequencer only orders the commands and spaces them out.

A free-running timer raises a refresh demand once per average refresh interval: 64 ms shared among 4,096 rows, or 15.625 µs, turned into clock cycles from the clock frequency parameter. A pending refresh is served before anything else. It closes every bank and then issues AUTO REFRESH. A separate request port loads the mode register from burst length, burst order, read latency and write-burst fields, and it also precharges first. Every timing limit is a cycle-count parameter, and the gaps between commands are filled with NOP.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is asserted and until the first clock after its release, the command outputs show the deselected state: chip select high, RAS#, CAS# and WE# high, bank and address zero.
- R2: An access issues ACTIVE (RAS#,CAS#,WE# = 011) with the request's bank on the bank pins and its row on the 12 address bits. Exactly T_RCD cycles later it issues READ (101) or WRITE (100) to the same bank, with the column on address bits 8:0.
- R3: On READ and WRITE, address bit 10 carries the request's auto-precharge flag, and address bits 11 and 9 are zero.
- R4: PRECHARGE (010) is always issued with address bit 10 high (all banks), bank pins zero and all other address bits zero. It comes before an access only when the previous access ran without auto-precharge. After an auto-precharged access, the next access starts directly with ACTIVE.
- R5: The next command comes no earlier than T_RP cycles after a PRECHARGE and no earlier than T_RCD cycles after an ACTIVE. When the sequence has nothing else to wait for, it comes exactly then.
- R6: A refresh demand arises every REF_INTERVAL clocks after reset, with REF_INTERVAL = CLK_MHZ*15625/1000. It is served by PRECHARGE all, then AUTO REFRESH (001) T_RP cycles later, and the next command comes T_RFC cycles after that.
- R7: When work is chosen, a pending refresh wins over a mode-register request, and a mode-register request wins over an access. The losing requester sees no acceptance that cycle.
- R8: A mode-register load issues PRECHARGE all, then T_RP cycles later LOAD MODE (000) with bank pins 00, address bits 11:10 and 8:7 zero, burst length on bits 2:0, burst order on bit 3, read latency on bits 6:4 and the single-write flag on bit 9. The next command comes T_MRD cycles later.
- R9: The next command comes T_RW cycles after a READ or WRITE.
- R10: With chip select low, every cycle that carries no command shows NOP (111).
- R11: `req_ready` and `mode_ack` are high only in a cycle where the sequencer is free and accepts that requester. The accepted request's fields are captured at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | An access request is presented |
| req_write | input | 1 | 1 = WRITE, 0 = READ |
| req_autopre | input | 1 | Close the row automatically after the burst |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Target row |
| req_col | input | 9 | Starting column |
| req_ready | output | 1 | The access request is taken at this clock edge |
| mode_req | input | 1 | Mode-register load requested |
| mode_burst | input | 3 | Burst length code |
| mode_interleave | input | 1 | Burst order: 1 = interleaved |
| mode_cas | input | 3 | Read latency code |
| mode_single_wr | input | 1 | Writes use single-location bursts |
| mode_ack | output | 1 | The mode request is taken at this clock edge |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed row / column / mode address |

## Verification
The assertions watch every cycle for the local command rules: READ or WRITE only directly after an ACTIVE to the same bank, at exactly the row-to-column gap; no command earlier than the minimum gap of the one before it; AUTO REFRESH only after a precharge-all; reserved mode bits held at zero; a refresh demand dropping once it is served; and no acceptance while a refresh is waiting. Other properties need a whole traffic history and only the bench's scenarios can show them. These are whether a precharge is left out correctly after an auto-precharged access, whether refreshes land at the right interval while traffic keeps arriving, and whether the exact cycle of every command matches a model that runs independently. The bench sends back-to-back and spaced requests, extreme bank, row and column values, and mode loads that collide with accesses and refreshes.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

   // Fixed device geometry: 4 banks, 4,096 rows, 512 columns.
   localparam int BANK_W   = 2;
   localparam int ROW_W    = 12;
   localparam int COL_W    = 9;
   localparam int ADDR_W   = 12;
   localparam int AP_BIT   = 10;

   // Command code on {RAS#, CAS#, WE#} with chip select low.
   typedef enum logic [2:0] {
      CMD_LMR = 3'b000,
      CMD_REF = 3'b001,
      CMD_PRE = 3'b010,
      CMD_ACT = 3'b011,
      CMD_WR  = 3'b100,
      CMD_RD  = 3'b101,
      CMD_NOP = 3'b111
   } sd_cmd_e;

   typedef enum logic [1:0] {
      JOB_IDLE,
      JOB_REF,
      JOB_MODE,
      JOB_ACC
   } seq_job_e;

   typedef enum logic {
      STEP_ACT,
      STEP_RW
   } acc_step_e;

   typedef struct packed {
      logic              write;
      logic              autopre;
      logic [BANK_W-1:0] bank;
      logic [ROW_W-1:0]  row;
      logic [COL_W-1:0]  col;
   } acc_req_t;

endpackage

// File: rtl/sdram_gap_counter.sv
module sdram_gap_counter #(
   parameter int MAX_GAP = 16,
   localparam int CW = $clog2(MAX_GAP + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          busy
);

   logic [CW-1:0] cnt_q;

   generate
      if (MAX_GAP < 1) begin : g_bad_gap
         $error("sdram_gap_counter: MAX_GAP must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

   // Each NOP slot used up brings the next command one cycle nearer.
   assert_gap_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
   parameter int INTERVAL = 1562,
   localparam int TW = $clog2(INTERVAL)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic pending
);

   logic [TW-1:0] tmr_q;
   logic          tick;

   generate
      if (INTERVAL < 2) begin : g_bad_interval
         $error("sdram_refresh_timer: INTERVAL must be at least 2");
      end
   endgenerate

   assign tick = (tmr_q == TW'(INTERVAL - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q   <= '0;
         pending <= 1'b0;
      end else begin
         tmr_q   <= tick ? '0 : tmr_q + 1'b1;
         pending <= (pending & ~ack) | tick;
      end
   end

   // A served demand disappears unless a new interval ends in the same cycle.
   assert_refresh_served_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !tick) |=> !pending);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
   import sdram_seq_pkg::*;
#(
   parameter int CLK_MHZ      = 100,
   parameter int T_RCD        = 3,
   parameter int T_RP         = 3,
   parameter int T_RFC        = 8,
   parameter int T_MRD        = 2,
   parameter int T_RW         = 6,
   parameter int REF_INTERVAL = CLK_MHZ * 15625 / 1000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic                 req_autopre,
   input  logic [BANK_W-1:0]    req_bank,
   input  logic [ROW_W-1:0]     req_row,
   input  logic [COL_W-1:0]     req_col,
   output logic                 req_ready,
   input  logic                 mode_req,
   input  logic [2:0]           mode_burst,
   input  logic                 mode_interleave,
   input  logic [2:0]           mode_cas,
   input  logic                 mode_single_wr,
   output logic                 mode_ack,
   output logic                 sd_cs_n,
   output logic                 sd_ras_n,
   output logic                 sd_cas_n,
   output logic                 sd_we_n,
   output logic [BANK_W-1:0]    sd_ba,
   output logic [ADDR_W-1:0]    sd_addr
);

   localparam int MAX_T = (T_RFC > T_RW) ? ((T_RFC > T_RCD) ? T_RFC : T_RCD)
                                         : ((T_RW  > T_RCD) ? T_RW  : T_RCD);
   localparam int MAX_G = (MAX_T > T_RP) ? ((MAX_T > T_MRD) ? MAX_T : T_MRD)
                                         : ((T_RP  > T_MRD) ? T_RP  : T_MRD);
   localparam int CW    = $clog2(MAX_G + 1);

   generate
      if (T_RCD < 1 || T_RP < 1 || T_RFC < 1 || T_MRD < 1 || T_RW < 1) begin : g_bad_t
         $error("sdram_cmd_seq: every timing parameter must be at least one cycle");
      end
      if (MAX_G > 200) begin : g_big_t
         $error("sdram_cmd_seq: timing parameters above 200 cycles are not supported");
      end
      if (CLK_MHZ < 1) begin : g_bad_clk
         $error("sdram_cmd_seq: CLK_MHZ must be positive");
      end
   endgenerate

   seq_job_e           job_q, job_d;
   acc_step_e          step_q, step_d;
   acc_req_t           lat_q, lat_d;
   logic [ADDR_W-1:0]  mword_q, mword_d;
   logic               open_q, open_d;
   logic               wait_busy, load, ref_pend, ref_ack, idle;
   logic [CW-1:0]      load_val;
   sd_cmd_e            cmd_d;
   logic [BANK_W-1:0]  ba_d;
   logic [ADDR_W-1:0]  addr_d;
   logic               cs_q;
   sd_cmd_e            cmd_q;

   sdram_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
      .clk(clk), .rst_n(rst_n), .ack(ref_ack), .pending(ref_pend));

   sdram_gap_counter #(.MAX_GAP(MAX_G)) u_gap (
      .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .busy(wait_busy));

   assign idle      = (job_q == JOB_IDLE) && !wait_busy;
   assign req_ready = idle && !ref_pend && !mode_req;
   assign mode_ack  = idle && !ref_pend && mode_req;

   always_comb begin
      job_d    = job_q;
      step_d   = step_q;
      lat_d    = lat_q;
      mword_d  = mword_q;
      open_d   = open_q;
      cmd_d    = CMD_NOP;
      ba_d     = '0;
      addr_d   = '0;
      load     = 1'b0;
      load_val = '0;
      ref_ack  = 1'b0;
      if (!wait_busy) begin
         unique case (job_q)
            JOB_IDLE: begin
               if (ref_pend || mode_req) begin
                  cmd_d          = CMD_PRE;
                  addr_d[AP_BIT] = 1'b1;
                  load           = 1'b1;
                  load_val       = CW'(T_RP - 1);
                  open_d         = 1'b0;
                  job_d          = ref_pend ? JOB_REF : JOB_MODE;
                  if (!ref_pend)
                     mword_d = {2'b00, mode_single_wr, 2'b00, mode_cas, mode_interleave, mode_burst};
               end else if (req_valid) begin
                  lat_d = '{write: req_write, autopre: req_autopre, bank: req_bank,
                            row: req_row, col: req_col};
                  job_d = JOB_ACC;
                  load  = 1'b1;
                  if (open_q) begin
                     cmd_d          = CMD_PRE;
                     addr_d[AP_BIT] = 1'b1;
                     load_val       = CW'(T_RP - 1);
                     open_d         = 1'b0;
                     step_d         = STEP_ACT;
                  end else begin
                     cmd_d    = CMD_ACT;
                     ba_d     = req_bank;
                     addr_d   = req_row;
                     load_val = CW'(T_RCD - 1);
                     step_d   = STEP_RW;
                  end
               end
            end
            JOB_REF: begin
               cmd_d    = CMD_REF;
               ref_ack  = 1'b1;
               load     = 1'b1;
               load_val = CW'(T_RFC - 1);
               job_d    = JOB_IDLE;
            end
            JOB_MODE: begin
               cmd_d    = CMD_LMR;
               addr_d   = mword_q;
               load     = 1'b1;
               load_val = CW'(T_MRD - 1);
               job_d    = JOB_IDLE;
            end
            JOB_ACC: begin
               load = 1'b1;
               ba_d = lat_q.bank;
               if (step_q == STEP_ACT) begin
                  cmd_d    = CMD_ACT;
                  addr_d   = lat_q.row;
                  load_val = CW'(T_RCD - 1);
                  step_d   = STEP_RW;
               end else begin
                  cmd_d          = lat_q.write ? CMD_WR : CMD_RD;
                  addr_d         = ADDR_W'(lat_q.col);
                  addr_d[AP_BIT] = lat_q.autopre;
                  load_val       = CW'(T_RW - 1);
                  open_d         = !lat_q.autopre;
                  job_d          = JOB_IDLE;
               end
            end
            default: job_d = JOB_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         job_q   <= JOB_IDLE;
         step_q  <= STEP_ACT;
         lat_q   <= '0;
         mword_q <= '0;
         open_q  <= 1'b0;
         cs_q    <= 1'b1;
         cmd_q   <= CMD_NOP;
         sd_ba   <= '0;
         sd_addr <= '0;
      end else begin
         job_q   <= job_d;
         step_q  <= step_d;
         lat_q   <= lat_d;
         mword_q <= mword_d;
         open_q  <= open_d;
         cs_q    <= 1'b0;
         cmd_q   <= cmd_d;
         sd_ba   <= ba_d;
         sd_addr <= addr_d;
      end
   end

   assign sd_cs_n                      = cs_q;
   assign {sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

   // ---------------- checker state built from the command pins ----------------
   logic       issued, seen_q;
   logic [2:0] last_q;
   logic [1:0] last_ba_q;
   logic [7:0] gap_q;
   logic [7:0] need_gap;

   assign issued = !sd_cs_n && ({sd_ras_n, sd_cas_n, sd_we_n} != 3'b111);

   always_comb begin
      unique case (last_q)
         3'b010:         need_gap = 8'(T_RP);
         3'b011:         need_gap = 8'(T_RCD);
         3'b100, 3'b101: need_gap = 8'(T_RW);
         3'b001:         need_gap = 8'(T_RFC);
         default:        need_gap = 8'(T_MRD);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q    <= 1'b0;
         last_q    <= 3'b111;
         last_ba_q <= '0;
         gap_q     <= '0;
      end else if (issued) begin
         seen_q    <= 1'b1;
         last_q    <= {sd_ras_n, sd_cas_n, sd_we_n};
         last_ba_q <= sd_ba;
         gap_q     <= 8'd1;
      end else if (gap_q != 8'hFF) begin
         gap_q     <= gap_q + 8'd1;
      end
   end

   assert_min_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (issued && seen_q) |-> (gap_q >= need_gap));

   assert_rw_follows_act_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (issued && sd_ras_n && !sd_cas_n) |->
         (last_q == 3'b011 && gap_q == 8'(T_RCD) && sd_ba == last_ba_q));

   assert_refresh_after_pre_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (issued && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b001) |->
         (last_q == 3'b010 && gap_q == 8'(T_RP)));

   assert_mode_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (issued && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b000) |->
         (sd_ba == '0 && sd_addr[11:10] == 2'b00 && sd_addr[8:7] == 2'b00));

   assert_refresh_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ref_pend |-> (!req_ready && !mode_ack));

   assert_single_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({req_ready && req_valid, mode_ack}));

endmodule

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb_top;

   localparam int CLK_MHZ = 100;
   localparam int T_RCD   = 3;
   localparam int T_RP    = 3;
   localparam int T_RFC   = 8;
   localparam int T_MRD   = 2;
   localparam int T_RW    = 6;
   localparam int REFI    = CLK_MHZ * 15625 / 1000;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n = 1'b0;
   logic        req_valid = 0, req_write = 0, req_autopre = 0;
   logic [1:0]  req_bank = '0;
   logic [11:0] req_row = '0;
   logic [8:0]  req_col = '0;
   logic        req_ready;
   logic        mode_req = 0, mode_interleave = 0, mode_single_wr = 0;
   logic [2:0]  mode_burst = '0, mode_cas = '0;
   logic        mode_ack;
   logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
   logic [1:0]  sd_ba;
   logic [11:0] sd_addr;

   sdram_cmd_seq #(.CLK_MHZ(CLK_MHZ), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC),
                   .T_MRD(T_MRD), .T_RW(T_RW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_autopre(req_autopre), .req_bank(req_bank), .req_row(req_row),
      .req_col(req_col), .req_ready(req_ready), .mode_req(mode_req),
      .mode_burst(mode_burst), .mode_interleave(mode_interleave),
      .mode_cas(mode_cas), .mode_single_wr(mode_single_wr), .mode_ack(mode_ack),
      .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
      .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr));

   int n_checks = 0;
   int n_errors = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: got %h expected %h at %0t", tag, what, got, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   typedef struct packed {
      logic [2:0]  c;
      logic [1:0]  ba;
      logic [11:0] a;
      logic [7:0]  gap;
   } ent_t;

   ent_t        pend_q[$];
   int          refi_t = 0;
   int          hold = 0;
   bit          rpend = 0, row_open = 0;
   logic        e_cs = 1'b1;
   logic [2:0]  e_cmd = 3'b111, last_cmd = 3'b111;
   logic [1:0]  e_ba = '0;
   logic [11:0] e_a = '0;
   bit          acc_flag = 0, macc_flag = 0;
   logic        rdy_s = 0, mack_s = 0;

   function automatic ent_t mk(input logic [2:0] c, input logic [1:0] ba,
                               input logic [11:0] a, input int gap);
      mk = '{c: c, ba: ba, a: a, gap: 8'(gap)};
   endfunction

   function automatic string tag_of(input logic cs, input logic [2:0] c,
                                    input logic [2:0] prev, input logic [11:0] a);
      if (cs) return "R1";
      case (c)
         3'b011: return "R2";
         3'b100, 3'b101: return a[10] ? "R3" : "R2";
         3'b010: return "R4";
         3'b001: return "R6";
         3'b000: return "R8";
         default: case (prev)
            3'b010: return "R5";
            3'b100, 3'b101: return "R9";
            default: return "R10";
         endcase
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         pend_q.delete();
         refi_t = 0; hold = 0; rpend = 0; row_open = 0;
         e_cs = 1'b1; e_cmd = 3'b111; e_ba = '0; e_a = '0; last_cmd = 3'b111;
      end else begin
         bit tick, acc_now, macc_now, blocked;
         tick = 0; acc_now = 0; macc_now = 0; blocked = 0;
         refi_t++;
         if (refi_t == REFI) begin refi_t = 0; tick = 1; end
         e_cs = 1'b0; e_cmd = 3'b111; e_ba = '0; e_a = '0;
         if (hold > 0) hold--;
         else begin
            if (pend_q.size() == 0) begin
               if (rpend) begin
                  blocked = 1;
                  pend_q.push_back(mk(3'b010, 2'b00, 12'h400, T_RP));
                  pend_q.push_back(mk(3'b001, 2'b00, 12'h000, T_RFC));
                  row_open = 0;
               end else if (mode_req) begin
                  macc_now = 1;
                  pend_q.push_back(mk(3'b010, 2'b00, 12'h400, T_RP));
                  pend_q.push_back(mk(3'b000, 2'b00,
                     {2'b00, mode_single_wr, 2'b00, mode_cas, mode_interleave, mode_burst}, T_MRD));
                  row_open = 0;
               end else if (req_valid) begin
                  acc_now = 1;
                  if (row_open) pend_q.push_back(mk(3'b010, 2'b00, 12'h400, T_RP));
                  pend_q.push_back(mk(3'b011, req_bank, req_row, T_RCD));
                  pend_q.push_back(mk(req_write ? 3'b100 : 3'b101, req_bank,
                                      {1'b0, req_autopre, 1'b0, req_col}, T_RW));
                  row_open = !req_autopre;
               end
            end
            if (pend_q.size() > 0) begin
               ent_t e;
               e = pend_q.pop_front();
               e_cmd = e.c; e_ba = e.ba; e_a = e.a;
               hold = int'(e.gap) - 1;
               if (e.c == 3'b001) rpend = 0;
            end
         end
         rpend = rpend | tick;
         if (req_valid)
            check(rdy_s == acc_now, (blocked || mode_req) ? "R7" : "R11",
                  "req_ready", 32'(rdy_s), 32'(acc_now));
         if (mode_req)
            check(mack_s == macc_now, blocked ? "R7" : "R11",
                  "mode_ack", 32'(mack_s), 32'(macc_now));
         if (acc_now)  acc_flag = 1;
         if (macc_now) macc_flag = 1;
      end
   end

   always @(negedge clk) begin
      rdy_s  = req_ready;
      mack_s = mode_ack;
      check({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr} ==
            {e_cs, e_cmd, e_ba, e_a}, tag_of(e_cs, e_cmd, last_cmd, e_a),
            "cs_cmd_ba_addr",
            32'({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr}),
            32'({e_cs, e_cmd, e_ba, e_a}));
      if (!e_cs && e_cmd != 3'b111) last_cmd = e_cmd;
   end

   // ---------------- stimulus ----------------
   task automatic do_req(input logic wr, input logic [1:0] bank, input logic [11:0] row,
                         input logic [8:0] col, input logic ap);
      @(negedge clk);
      acc_flag = 0;
      req_valid = 1; req_write = wr; req_bank = bank; req_row = row;
      req_col = col; req_autopre = ap;
      do @(negedge clk); while (!acc_flag);
      req_valid = 0;
   endtask

   task automatic do_mode(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                          input logic wb);
      @(negedge clk);
      macc_flag = 0;
      mode_req = 1; mode_burst = bl; mode_interleave = bt; mode_cas = cl; mode_single_wr = wb;
      do @(negedge clk); while (!macc_flag);
      mode_req = 0;
   endtask

   task automatic do_both(input int i);
      @(negedge clk);
      acc_flag = 0; macc_flag = 0;
      mode_req = 1; mode_burst = 3'(i); mode_cas = 3'b011; mode_interleave = i[0];
      mode_single_wr = i[1];
      req_valid = 1; req_write = i[0]; req_bank = 2'(i); req_row = 12'(i * 97);
      req_col = 9'(i * 13); req_autopre = i[2];
      while (mode_req || req_valid) begin
         @(negedge clk);
         if (macc_flag) mode_req = 0;
         if (acc_flag)  req_valid = 0;
      end
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;                                   // R1 checked while held
      do_req(1'b1, 2'd2, 12'h5A5, 9'h1F0, 1'b0);       // R2, row left open
      do_req(1'b0, 2'd1, 12'hFFF, 9'h1FF, 1'b1);       // R4 precharge first, R3 flag
      do_req(1'b0, 2'd3, 12'h000, 9'h000, 1'b1);       // R4 straight to ACTIVE
      do_mode(3'b011, 1'b0, 3'b010, 1'b0);             // R8
      do_req(1'b1, 2'd0, 12'h800, 9'h100, 1'b0);
      do_mode(3'b111, 1'b1, 3'b011, 1'b1);             // R8 after open row
      do_both(5);                                      // R7 mode beats access
      for (int i = 0; i < 300; i++) begin              // R6, R7 under steady traffic
         do_req(i[0], 2'(i), 12'(i * 389), 9'(i * 77), i[1] ^ i[2]);
         if (i % 37 == 0) do_both(i);
         if (i % 11 == 0) repeat (i % 7) @(negedge clk);
      end
      repeat (2000) @(negedge clk);                    // R6 refresh in a quiet bus
      do_req(1'b1, 2'd3, 12'hFFF, 9'h1FF, 1'b0);
      repeat (30) @(negedge clk);
      finish_run();
   end

endmodule